// File: doc/BRIEF.md
# Microprogram Sequencer with Condition-Selected Branch

This block steps through a small writeable control store and presents the control-function bits of the current microinstruction to a datapath. It holds a microprogram counter, which is the address of the next word to fetch, and a control word register, which holds the word fetched last. Every microinstruction has three fields: a condition select, a branch target and the control bits.

On every clock edge the word at the counter is fetched into the control word register. A condition multiplexer evaluates that same word's select field against the external zero flag. The counter then either takes the word's branch target or steps by one. Because the branch is resolved while its own word is fetched, no delay slot follows a branch word.

A start strobe loads the counter from an external address and inserts an empty control word. Software-side loading of the program uses a simple synchronous write port into the store.

Top module: `ucode_seq`

## Requirements
- R1: A synchronous reset clears the counter and the control word register, so `ctrl_o` is zero during reset and the first fetch after reset reads address 0.
- R2: A store word is laid out as bits [11:10] condition select, bits [9:7] branch target and bits [6:0] control. `ctrl_o` shows the control field of the fetched word unchanged, whatever its select value.
- R3: On an edge without a start strobe, the word at the counter enters the control word register, and `ctrl_o` shows it in the following cycle.
- R4: With `start_load_i` high, the counter takes `start_addr_i` and the control word register clears to zero at that edge. No fetch decision is made in that cycle.
- R5: Select 00 never branches. The counter steps by one whatever the branch field and `zero_i` hold.
- R6: Select 01 branches when `zero_i` is 0 in the cycle that word is fetched, and steps by one otherwise.
- R7: Select 10 always branches to the word's target, so a word that targets itself halts the sequence.
- R8: Select 11 is reserved and never branches.
- R9: The counter steps from 7 back to 0.
- R10: Addresses at or above the store depth (6) read as an all-zero word, and writes to them are dropped.
- R11: A write takes effect at the clock edge. A fetch from the same address at that edge still receives the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_load_i | input | 1 | Load the counter from the start address |
| start_addr_i | input | 3 | Microprogram entry address |
| zero_i | input | 1 | External zero status flag |
| cs_we_i | input | 1 | Control store write enable |
| cs_waddr_i | input | 3 | Control store write address |
| cs_wdata_i | input | 12 | Control store write word |
| ctrl_o | output | 7 | Control-function bits from the control word register |

## Verification
The hardest situation to reach is a write that lands on the very address being fetched while that address is a self-targeting halt. Only then does the old-versus-new content of a word become visible, through a change in control bits one cycle later. The directed part of the stimulus parks the sequencer on such a halt and rewrites that word in place. Afterwards it steers the counter through the unbacked addresses 6 and 7 and across the wrap to 0. The random part then mixes writes, start strobes and zero-flag changes freely.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 7;
    localparam int SEL_W  = 2;
    localparam int WORD_W = SEL_W + ADDR_W + CTRL_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE   = 2'b00,
        SEL_ZCLEAR = 2'b01,
        SEL_ALWAYS = 2'b10,
        SEL_RSVD   = 2'b11
    } sel_e;

    typedef struct packed {
        sel_e  sel;
        addr_t target;
        ctrl_t ctrl;
    } uword_t;

    typedef struct packed {
        addr_t mpc;
        ctrl_t cwr;
    } seq_state_t;
endpackage

// File: rtl/ucs_store.sv
module ucs_store
    import ucs_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  addr_t  waddr,
    input  uword_t wdata,
    input  addr_t  raddr,
    output uword_t rdata
);
    localparam int SPAN = 1 << ADDR_W;
    localparam int ROWS = (DEPTH < SPAN) ? DEPTH : SPAN;

    uword_t word_q [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic   hit_w;
        uword_t word_d;
        always_comb begin
            hit_w  = we && (waddr == addr_t'(g));
            word_d = hit_w ? wdata : word_q[g];
        end
        always_ff @(posedge clk) begin
            word_q[g] <= word_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (raddr == addr_t'(i)) begin
                rdata = word_q[i];
            end
        end
    end

    // R10: unbacked addresses read as an empty word
    a_r10_unbacked_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(raddr) >= ROWS) |-> (rdata == '0));
endmodule

// File: rtl/ucs_cond_sel.sv
module ucs_cond_sel
    import ucs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_e sel,
    input  logic zero,
    output logic take
);
    always_comb begin
        unique case (sel)
            SEL_NONE:   take = 1'b0;
            SEL_ZCLEAR: take = ~zero;
            SEL_ALWAYS: take = 1'b1;
            SEL_RSVD:   take = 1'b0;
            default:    take = 1'b0;
        endcase
    end

    // R8: reserved select never branches
    a_r8_reserved_false: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_RSVD) |-> !take);
    // R5: plain operate word never branches
    a_r5_none_false: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> !take);
endmodule

// File: rtl/ucs_next_addr.sv
module ucs_next_addr
    import ucs_pkg::*;
(
    input  logic  load,
    input  addr_t start_addr,
    input  addr_t mpc,
    input  logic  take,
    input  addr_t target,
    output addr_t mpc_d
);
    addr_t step_w;

    always_comb begin
        step_w = mpc + addr_t'(1);
        if (load) begin
            mpc_d = start_addr;
        end else if (take) begin
            mpc_d = target;
        end else begin
            mpc_d = step_w;
        end
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucs_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              zero_i,
    input  logic              cs_we_i,
    input  logic [ADDR_W-1:0] cs_waddr_i,
    input  logic [WORD_W-1:0] cs_wdata_i,
    output logic [CTRL_W-1:0] ctrl_o
);
    seq_state_t state_d, state_q;
    uword_t     fetch_w;
    logic       take_w;
    addr_t      mpc_next_w;

    ucs_store #(.DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cs_we_i),
        .waddr (cs_waddr_i),
        .wdata (uword_t'(cs_wdata_i)),
        .raddr (state_q.mpc),
        .rdata (fetch_w)
    );

    ucs_cond_sel cond_i (
        .clk  (clk),
        .rst  (rst),
        .sel  (fetch_w.sel),
        .zero (zero_i),
        .take (take_w)
    );

    ucs_next_addr next_i (
        .load       (start_load_i),
        .start_addr (start_addr_i),
        .mpc        (state_q.mpc),
        .take       (take_w),
        .target     (fetch_w.target),
        .mpc_d      (mpc_next_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.mpc = mpc_next_w;
        state_d.cwr = start_load_i ? '0 : fetch_w.ctrl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_o = state_q.cwr;

    // R4: start strobe loads the entry point and empties the control word
    a_r4_start_load: assert property (@(posedge clk) disable iff (rst)
        start_load_i |=> (state_q.mpc == $past(start_addr_i)) && (state_q.cwr == '0));
    // R3: fetched control field lands in the register
    a_r3_fetch_cwr: assert property (@(posedge clk) disable iff (rst)
        !start_load_i |=> (state_q.cwr == $past(fetch_w.ctrl)));
    // R7: unconditional select jumps to the target
    a_r7_always_jump: assert property (@(posedge clk) disable iff (rst)
        (!start_load_i && fetch_w.sel == SEL_ALWAYS) |=> (state_q.mpc == $past(fetch_w.target)));
    // R9: non-branching step wraps modulo the address space
    a_r9_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (!start_load_i && fetch_w.sel == SEL_RSVD) |=> (state_q.mpc == addr_t'($past(state_q.mpc) + 1)));
    // R6: zero-clear select follows the flag
    a_r6_zero_clear: assert property (@(posedge clk) disable iff (rst)
        (!start_load_i && fetch_w.sel == SEL_ZCLEAR && zero_i) |=> (state_q.mpc == addr_t'($past(state_q.mpc) + 1)));
endmodule

// File: tb/ucode_seq_tb_top.sv
`timescale 1ns/1ps
module ucode_seq_tb_top;
    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_load_i = 1'b0;
    logic [2:0]  start_addr_i = '0;
    logic        zero_i = 1'b0;
    logic        cs_we_i = 1'b0;
    logic [2:0]  cs_waddr_i = '0;
    logic [11:0] cs_wdata_i = '0;
    logic [6:0]  ctrl_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [11:0] m_mem [8];
    logic [2:0]  m_mpc = '0;
    logic [6:0]  m_cwr = '0;

    always #2 clk = ~clk;

    ucode_seq #(.DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_load_i (start_load_i),
        .start_addr_i (start_addr_i),
        .zero_i       (zero_i),
        .cs_we_i      (cs_we_i),
        .cs_waddr_i   (cs_waddr_i),
        .cs_wdata_i   (cs_wdata_i),
        .ctrl_o       (ctrl_o)
    );

    function automatic logic f_take(input logic [1:0] sel, input logic z);
        case (sel)
            2'b01:   return ~z;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [11:0] f_word(input logic [1:0] sel, input logic [2:0] tgt,
                                           input logic [6:0] c);
        return {sel, tgt, c};
    endfunction

    task automatic check(input string tag, input logic [6:0] exp);
        n_vec++;
        if (ctrl_o !== exp) begin
            n_bad++;
            $display("FAIL %s: ctrl_o=%b expected %b", tag, ctrl_o, exp);
        end
    endtask

    task automatic step(input logic ld, input logic [2:0] sa, input logic z,
                        input logic we, input logic [2:0] wa, input logic [11:0] wd,
                        input string tag);
        logic [11:0] w;
        start_load_i = ld; start_addr_i = sa; zero_i = z;
        cs_we_i = we; cs_waddr_i = wa; cs_wdata_i = wd;
        w = (int'(m_mpc) < DEPTH) ? m_mem[m_mpc] : 12'h000;
        if (ld) begin
            m_mpc = sa; m_cwr = '0;
        end else begin
            m_cwr = w[6:0];
            m_mpc = f_take(w[11:10], z) ? w[9:7] : m_mpc + 3'd1;
        end
        if (we && int'(wa) < DEPTH) m_mem[wa] = wd;
        @(posedge clk);
        @(negedge clk);
        cs_we_i = 1'b0; start_load_i = 1'b0;
        check(tag, m_cwr);
    endtask

    task automatic run(input logic z, input string tag);
        step(1'b0, 3'd0, z, 1'b0, 3'd0, 12'h000, tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_mem[i] = 12'h000;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        // program loaded while reset holds the sequencer
        begin
            logic [11:0] prog [6];
            prog[0] = f_word(2'b00, 3'd0, 7'b0000011);
            prog[1] = f_word(2'b00, 3'd0, 7'b0000100);
            prog[2] = f_word(2'b00, 3'd0, 7'b0001000);
            prog[3] = f_word(2'b01, 3'd2, 7'b0000000);
            prog[4] = f_word(2'b00, 3'd0, 7'b0010000);
            prog[5] = f_word(2'b10, 3'd5, 7'b0000000);
            for (int i = 0; i < 6; i++) begin
                cs_we_i = 1'b1; cs_waddr_i = 3'(i); cs_wdata_i = prog[i];
                m_mem[i] = prog[i];
                @(posedge clk);
                @(negedge clk);
                check("R1 reset holds ctrl at zero", 7'b0);
            end
            cs_we_i = 1'b0;
        end
        rst = 1'b0;
        run(1'b1, "R1 first fetch from address 0");
        run(1'b1, "R3 sequential fetch");
        run(1'b1, "R3 sequential fetch");
        run(1'b0, "R6 branch word fetched with Z=0");
        run(1'b1, "R6 taken branch returns to 2");
        run(1'b1, "R6 branch word fetched with Z=1");
        run(1'b1, "R6 not taken falls to 4");
        run(1'b0, "R7 halt word fetched");
        run(1'b0, "R7 halt repeats");
        // rewrite the halting word in place while it is fetched
        step(1'b0, 3'd0, 1'b0, 1'b1, 3'd5, f_word(2'b11, 3'd0, 7'b1000000),
             "R11 same-edge fetch sees old word");
        run(1'b0, "R11 new word visible next fetch");
        run(1'b0, "R8 reserved select stepped to 6, R10 zero word");
        run(1'b0, "R9 R10 address 7 zero word");
        run(1'b1, "R9 wrap to address 0");
        step(1'b0, 3'd0, 1'b0, 1'b1, 3'd7, f_word(2'b10, 3'd1, 7'b1111111),
             "R10 write beyond depth");
        step(1'b1, 3'd7, 1'b0, 1'b0, 3'd0, 12'h000, "R4 load clears ctrl");
        run(1'b0, "R10 dropped write reads as zero");
        step(1'b0, 3'd0, 1'b0, 1'b1, 3'd1, f_word(2'b00, 3'd5, 7'b0100000), "R5 rewrite word 1");
        step(1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 12'h000, "R4 load entry 1");
        run(1'b0, "R5 R2 no-branch word with target field");
        run(1'b0, "R5 stepped to 2 not 5");
        step(1'b0, 3'd0, 1'b0, 1'b1, 3'd4, f_word(2'b10, 3'd0, 7'b1010101), "R2 write jump word");
        step(1'b1, 3'd4, 1'b1, 1'b0, 3'd0, 12'h000, "R4 load entry 4");
        run(1'b1, "R2 control field verbatim on jump word");
        run(1'b1, "R7 jump lands at 0");
        for (int k = 0; k < 3000; k++) begin
            logic ld, we;
            ld = ($urandom % 10) == 0;
            we = ($urandom % 6) == 0;
            step(ld, 3'($urandom), 1'($urandom), we, 3'($urandom), 12'($urandom),
                 "R3 R6 R7 R8 random mix");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule